// File: doc/BRIEF.md
# Dual-Mode USB CRC Engine

A bit-serial CRC unit for a USB serial interface engine. Firmware or a packet sequencer first pulses `start_i`, which picks the checksum kind and loads the preset value. It then hands over one data byte at a time. The engine works through each accepted byte one bit per clock, least significant bit first. While it does so, `busy_o` is high.

Two checksum kinds are built in, and neither is configurable:
- the 5-bit token checksum, which covers the address and endpoint fields;
- the 16-bit data checksum, which covers packet payloads.

For the 16-bit kind, a second select chooses the USB polynomial or the CCITT polynomial. The packet identifier, the sync pattern, NRZI coding, bit stuffing and the line itself are handled elsewhere.

The engine serves both directions:
- **Transmit.** `tx_crc_o` holds the inverted remainder, ready to append LSB first.
- **Receive.** The received checksum bits are fed through the engine after the payload. `resid_ok_o` then reports whether the remainder has reached the fixed residual of a good packet.

In token mode a byte may carry fewer than eight bits. This lets the 11 token bits go in as one full byte followed by three bits.

Top module: `usbcrc_core`

## Requirements
- R1: A pulse on `start_i` latches the checksum kind: `sel16_i`=0 gives 5-bit token mode, and `sel16_i`=1 gives 16-bit mode, where `ccitt_i`=1 picks CCITT. It presets the remainder to 0xFFFF (16-bit) or 0x001F (token) and clears `overrun_o`. A byte offered in the same cycle as `start_i` is dropped and does not set `overrun_o`.
- R2: A byte is accepted when `byte_valid_i` is high and `busy_o` is low. From the next cycle, `busy_o` is high for exactly one cycle per bit (eight in 16-bit mode). In each of those cycles one bit is consumed, LSB first. While the engine is idle with no start and no byte offered, the remainder holds.
- R3: In 16-bit USB mode the engine uses the reflected polynomial 0xA001. Feeding the ASCII bytes "123456789" gives `tx_crc_o` = 0xB4C8.
- R4: In 16-bit CCITT mode the engine uses the reflected polynomial 0x8408. The same nine bytes give `tx_crc_o` = 0x906E.
- R5: Token mode uses the reflected polynomial 0x14. Bits 15:5 of the remainder and of `tx_crc_o` stay zero. `nbits_i` values 1 to 8 consume that many low bits of the byte. The nine ASCII bytes above give `tx_crc_o` = 0x19.
- R6: `tx_crc_o` is the bitwise inverse of `rem_o` over the active width (16 bits, or bits 4:0 in token mode).
- R7: `resid_ok_o` is high exactly when the remainder equals the good-packet residual of the latched kind:
  - USB 16-bit: 0xB001 (0x800D in normal bit order).
  - CCITT: 0xF0B8.
  - Token: 0x06 (0x0C in normal order).
- R8: A byte offered while `busy_o` is high is rejected and leaves the remainder untouched. It sets `overrun_o`, which stays high until the next `start_i`.
- R9: Changing `sel16_i` or `ccitt_i` without a `start_i` has no effect on the ongoing computation.
- R10: In token mode an `nbits_i` of 0 or above 8 acts as 8. In 16-bit mode `nbits_i` is ignored and every byte takes eight bits.
- R11: After synchronous reset the engine is idle in 16-bit USB mode:
  - `rem_o` = 0xFFFF
  - `tx_crc_o` = 0
  - `resid_ok_o`, `busy_o` and `overrun_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Preset remainder and latch the checksum kind |
| sel16_i | input | 1 | 1: 16-bit data checksum, 0: 5-bit token checksum |
| ccitt_i | input | 1 | In 16-bit mode, 1 selects the CCITT polynomial |
| byte_valid_i | input | 1 | Offers `byte_i` for processing |
| byte_i | input | 8 | Data byte, consumed LSB first |
| nbits_i | input | 4 | Bits to consume in token mode (0 or >8 means 8) |
| busy_o | output | 1 | A byte is being shifted through |
| overrun_o | output | 1 | Sticky: a byte was offered while busy |
| rem_o | output | 16 | Current remainder (reflected order) |
| tx_crc_o | output | 16 | Inverted remainder over the active width |
| resid_ok_o | output | 1 | Remainder equals the good-packet residual |

## Verification
The assertions assume that `start_i` and `byte_valid_i` are sampled synchronously, and that the mode selects matter only in the cycle where `start_i` is high. The busy-length property also assumes that a run of busy cycles ends by itself, not through a new start. The bench therefore drives all inputs at the falling edge. It offers a byte for a single cycle and waits for `busy_o` to drop before the next byte, except in the deliberate overrun case. It compares each result with a bit-level model of the stated polynomials and with the published check values. Residual tests append the inverted checksum LSB first, exactly as a transmitter would.

// File: rtl/usbcrc_pkg.sv
package usbcrc_pkg;

  localparam int CRC_W = 16;

  localparam logic [CRC_W-1:0] POLY_USB16  = 16'hA001;
  localparam logic [CRC_W-1:0] POLY_CCITT  = 16'h8408;
  localparam logic [CRC_W-1:0] POLY_TOK5   = 16'h0014;

  localparam logic [CRC_W-1:0] PRESET_16   = 16'hFFFF;
  localparam logic [CRC_W-1:0] PRESET_5    = 16'h001F;

  localparam logic [CRC_W-1:0] RESID_USB16 = 16'hB001;
  localparam logic [CRC_W-1:0] RESID_CCITT = 16'hF0B8;
  localparam logic [CRC_W-1:0] RESID_TOK5  = 16'h0006;

  typedef enum logic [1:0] {
    KIND_TOK5    = 2'd0,
    KIND_USB16   = 2'd1,
    KIND_CCITT16 = 2'd2
  } crc_kind_e;

  function automatic crc_kind_e kind_from(input logic wide, input logic ccitt);
    if (!wide)      return KIND_TOK5;
    else if (ccitt) return KIND_CCITT16;
    else            return KIND_USB16;
  endfunction

  function automatic logic [CRC_W-1:0] poly_of(input crc_kind_e k);
    case (k)
      KIND_TOK5:    return POLY_TOK5;
      KIND_CCITT16: return POLY_CCITT;
      default:      return POLY_USB16;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] preset_of(input crc_kind_e k);
    return (k == KIND_TOK5) ? PRESET_5 : PRESET_16;
  endfunction

  function automatic logic [CRC_W-1:0] mask_of(input crc_kind_e k);
    return (k == KIND_TOK5) ? 16'h001F : 16'hFFFF;
  endfunction

  function automatic logic [CRC_W-1:0] resid_of(input crc_kind_e k);
    case (k)
      KIND_TOK5:    return RESID_TOK5;
      KIND_CCITT16: return RESID_CCITT;
      default:      return RESID_USB16;
    endcase
  endfunction

endpackage

// File: rtl/usbcrc_bit_step.sv
module usbcrc_bit_step
  import usbcrc_pkg::*;
(
  input  logic [CRC_W-1:0] crc_i,
  input  logic             bit_i,
  input  crc_kind_e        kind_i,
  output logic [CRC_W-1:0] crc_o
);

  logic             fb;
  logic [CRC_W-1:0] shifted;

  always_comb begin
    fb      = crc_i[0] ^ bit_i;
    shifted = crc_i >> 1;
    crc_o   = fb ? (shifted ^ poly_of(kind_i)) : shifted;
  end

endmodule

// File: rtl/usbcrc_bit_seq.sv
module usbcrc_bit_seq #(
  parameter  int BYTE_W = 8,
  localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic              partial_ok_i,
  output logic              step_o,
  output logic              bit_o,
  output logic              busy_o,
  output logic              overrun_o
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              ovr_q;
  logic [CNT_W-1:0]  len;
  logic              accept;

  always_comb begin
    if (!partial_ok_i || nbits_i == '0 || nbits_i > FULL) len = FULL;
    else                                                  len = nbits_i;
    accept = valid_i && !busy_q && !start_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (valid_i && busy_q) ovr_q <= 1'b1;
      if (accept) begin
        sh_q   <= data_i;
        cnt_q  <= len;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  assign step_o    = busy_q;
  assign bit_o     = sh_q[0];
  assign busy_o    = busy_q;
  assign overrun_o = ovr_q;

endmodule

// File: rtl/usbcrc_core.sv
module usbcrc_core
  import usbcrc_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              sel16_i,
  input  logic              ccitt_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [CNT_W-1:0]  nbits_i,
  output logic              busy_o,
  output logic              overrun_o,
  output logic [CRC_W-1:0]  rem_o,
  output logic [CRC_W-1:0]  tx_crc_o,
  output logic              resid_ok_o
);

  crc_kind_e        kind_q, kind_d;
  logic [CRC_W-1:0] crc_q, crc_d, crc_step;
  logic [CRC_W-1:0] tx_q;
  logic             ok_q;
  logic             step, sbit;

  usbcrc_bit_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .valid_i      (byte_valid_i),
    .data_i       (byte_i),
    .nbits_i      (nbits_i),
    .partial_ok_i (kind_q == KIND_TOK5),
    .step_o       (step),
    .bit_o        (sbit),
    .busy_o       (busy_o),
    .overrun_o    (overrun_o)
  );

  usbcrc_bit_step u_step (
    .crc_i  (crc_q),
    .bit_i  (sbit),
    .kind_i (kind_q),
    .crc_o  (crc_step)
  );

  always_comb begin
    kind_d = start_i ? kind_from(sel16_i, ccitt_i) : kind_q;
    if (start_i)   crc_d = preset_of(kind_d);
    else if (step) crc_d = crc_step;
    else           crc_d = crc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= KIND_USB16;
      crc_q  <= PRESET_16;
      tx_q   <= '0;
      ok_q   <= 1'b0;
    end else begin
      kind_q <= kind_d;
      crc_q  <= crc_d;
      tx_q   <= ~crc_d & mask_of(kind_d);
      ok_q   <= (crc_d == resid_of(kind_d));
    end
  end

  assign rem_o      = crc_q;
  assign tx_crc_o   = tx_q;
  assign resid_ok_o = ok_q;

endmodule

// File: rtl/usbcrc_core_chk.sv
module usbcrc_core_chk #(
  parameter  int BYTE_W = 8,
  localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              sel16_i,
  input logic              ccitt_i,
  input logic              byte_valid_i,
  input logic [BYTE_W-1:0] byte_i,
  input logic [CNT_W-1:0]  nbits_i,
  input logic              busy_o,
  input logic              overrun_o,
  input logic [15:0]       rem_o,
  input logic [15:0]       tx_crc_o,
  input logic              resid_ok_o
);

  logic       wide_q;
  logic [7:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q <= 1'b1;
      run_q  <= '0;
    end else begin
      if (start_i) wide_q <= sel16_i;
      run_q <= busy_o ? run_q + 8'd1 : 8'd0;
    end
  end

  // R1: preset value follows the selected width
  p_start_preset_r1: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (rem_o == ($past(sel16_i) ? 16'hFFFF : 16'h001F)));

  // R2: a full byte in 16-bit mode keeps busy for exactly BYTE_W cycles
  p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
    (wide_q && $fell(busy_o) && !$past(start_i)) |-> (run_q == 8'(BYTE_W)));

  // R2: idle engine holds its remainder
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !byte_valid_i && !start_i) |=> $stable(rem_o));

  // R8: offer while busy raises overrun
  p_reject_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && byte_valid_i && !start_i) |=> overrun_o);

  // R8: overrun is sticky until start
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (overrun_o && !start_i) |=> overrun_o);

  // R5: token mode keeps the upper bits clear
  p_tok_width_r5: assert property (@(posedge clk) disable iff (rst)
    !wide_q |-> (rem_o[15:5] == 11'd0 && tx_crc_o[15:5] == 11'd0));

endmodule

bind usbcrc_core usbcrc_core_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/usbcrc_core_tb.sv
module usbcrc_core_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        sel16_i = 1'b1;
  logic        ccitt_i = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic [3:0]  nbits_i = 4'd8;
  logic        busy_o, overrun_o, resid_ok_o;
  logic [15:0] rem_o, tx_crc_o;

  int checks = 0;
  int errors = 0;

  // model state
  logic [15:0] m_crc;
  logic        m_wide, m_cc;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbcrc_core u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .sel16_i(sel16_i),
    .ccitt_i(ccitt_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .nbits_i(nbits_i), .busy_o(busy_o), .overrun_o(overrun_o),
    .rem_o(rem_o), .tx_crc_o(tx_crc_o), .resid_ok_o(resid_ok_o)
  );

  // {restart, sel16, ccitt, nbits[3:0], data[7:0]}
  localparam logic [14:0] VEC [16] = '{
    {1'b1, 1'b1, 1'b0, 4'd8, 8'hA5},
    {1'b0, 1'b1, 1'b0, 4'd8, 8'h00},
    {1'b0, 1'b1, 1'b0, 4'd8, 8'hFF},
    {1'b0, 1'b1, 1'b0, 4'd8, 8'h3C},
    {1'b1, 1'b1, 1'b1, 4'd8, 8'h01},
    {1'b0, 1'b1, 1'b1, 4'd8, 8'h80},
    {1'b0, 1'b1, 1'b1, 4'd8, 8'h7E},
    {1'b0, 1'b1, 1'b1, 4'd8, 8'hC3},
    {1'b1, 1'b0, 1'b0, 4'd8, 8'h95},
    {1'b0, 1'b0, 1'b0, 4'd3, 8'h07},
    {1'b1, 1'b0, 1'b0, 4'd1, 8'h01},
    {1'b0, 1'b0, 1'b0, 4'd5, 8'h1A},
    {1'b0, 1'b0, 1'b0, 4'd7, 8'h55},
    {1'b1, 1'b1, 1'b0, 4'd2, 8'h12},
    {1'b0, 1'b1, 1'b0, 4'd8, 8'hEE},
    {1'b0, 1'b1, 1'b0, 4'd8, 8'h00}
  };

  localparam logic [7:0] ASCII9 [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35,
                                        8'h36, 8'h37, 8'h38, 8'h39};

  function automatic logic [15:0] m_poly(input logic w, input logic c);
    if (!w) return 16'h0014;
    return c ? 16'h8408 : 16'hA001;
  endfunction

  function automatic logic [15:0] m_feed(input logic [15:0] crc, input logic [7:0] d,
                                         input int n, input logic w, input logic c);
    logic [15:0] r = crc;
    int cnt = w ? 8 : ((n == 0 || n > 8) ? 8 : n);
    for (int i = 0; i < cnt; i++) begin
      logic fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ m_poly(w, c);
    end
    return r;
  endfunction

  function automatic logic [15:0] m_tx(input logic [15:0] crc, input logic w);
    return ~crc & (w ? 16'hFFFF : 16'h001F);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_start(input logic w, input logic c);
    start_i = 1'b1; sel16_i = w; ccitt_i = c;
    @(negedge clk);
    start_i = 1'b0;
    m_wide = w; m_cc = c;
    m_crc = w ? 16'hFFFF : 16'h001F;
  endtask

  task automatic send(input logic [7:0] d, input logic [3:0] n, output int busy_cycles);
    byte_valid_i = 1'b1; byte_i = d; nbits_i = n;
    @(negedge clk);
    byte_valid_i = 1'b0;
    busy_cycles = 0;
    while (busy_o) begin
      busy_cycles++;
      @(negedge clk);
    end
    m_crc = m_feed(m_crc, d, int'(n), m_wide, m_cc);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bc;
    logic [15:0] t;
    m_crc = 16'hFFFF; m_wide = 1'b1; m_cc = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11: reset state
    check("R11", "rem", 32'(rem_o), 32'hFFFF);
    check("R11", "tx", 32'(tx_crc_o), 32'h0);
    check("R11", "ok/busy/ovr", {29'd0, resid_ok_o, busy_o, overrun_o}, 32'd0);

    // vector table walk (R2, R3, R4, R5, R6)
    for (int i = 0; i < 16; i++) begin
      if (VEC[i][14]) begin
        do_start(VEC[i][13], VEC[i][12]);
        check("R1", "preset", 32'(rem_o), VEC[i][13] ? 32'hFFFF : 32'h1F);
      end
      send(VEC[i][7:0], VEC[i][11:8], bc);
      check(m_wide ? "R3" : "R5", "table rem", 32'(rem_o), 32'(m_crc));
      check("R6", "table tx", 32'(tx_crc_o), 32'(m_tx(m_crc, m_wide)));
      check("R2", "table busy cycles", 32'(bc),
            32'(m_wide ? 8 : ((VEC[i][11:8] == 0 || VEC[i][11:8] > 8) ? 8 : VEC[i][11:8])));
    end

    // R3: published check value, USB 16-bit
    do_start(1'b1, 1'b0);
    for (int i = 0; i < 9; i++) send(ASCII9[i], 4'd8, bc);
    check("R3", "usb16 check", 32'(tx_crc_o), 32'hB4C8);

    // R7: append inverted checksum, expect residual
    t = tx_crc_o;
    send(t[7:0], 4'd8, bc);
    send(t[15:8], 4'd8, bc);
    check("R7", "usb16 residual rem", 32'(rem_o), 32'hB001);
    check("R7", "usb16 residual ok", 32'(resid_ok_o), 32'd1);

    // R4: CCITT check and residual
    do_start(1'b1, 1'b1);
    for (int i = 0; i < 9; i++) send(ASCII9[i], 4'd8, bc);
    check("R4", "ccitt check", 32'(tx_crc_o), 32'h906E);
    t = tx_crc_o;
    send(t[7:0], 4'd8, bc);
    send(t[15:8], 4'd8, bc);
    check("R7", "ccitt residual ok", 32'(resid_ok_o), 32'd1);

    // R5: token mode check value over full bytes
    do_start(1'b0, 1'b0);
    for (int i = 0; i < 9; i++) send(ASCII9[i], 4'd8, bc);
    check("R5", "tok5 check", 32'(tx_crc_o), 32'h19);

    // R5/R7: 11-bit token as 8 + 3 bits, then 5 checksum bits
    do_start(1'b0, 1'b0);
    send({1'b0, 7'h15}, 4'd8, bc);      // address 0x15, endpoint bit0 = 0
    send({5'd0, 3'b111}, 4'd3, bc);     // endpoint bits 3:1
    check("R5", "token 3-bit busy", 32'(bc), 32'd3);
    t = tx_crc_o;
    check("R6", "token tx", 32'(t), 32'(m_tx(m_crc, 1'b0)));
    send({3'd0, t[4:0]}, 4'd5, bc);
    check("R7", "token residual rem", 32'(rem_o), 32'h0006);
    check("R7", "token residual ok", 32'(resid_ok_o), 32'd1);

    // R7: corrupted token checksum is not accepted
    do_start(1'b0, 1'b0);
    send({1'b0, 7'h15}, 4'd8, bc);
    send({5'd0, 3'b111}, 4'd3, bc);
    t = tx_crc_o ^ 16'h0004;
    send({3'd0, t[4:0]}, 4'd5, bc);
    check("R7", "bad token ok", 32'(resid_ok_o), 32'd0);

    // R9: mode inputs change mid-stream without start
    do_start(1'b1, 1'b0);
    sel16_i = 1'b0; ccitt_i = 1'b1;
    for (int i = 0; i < 9; i++) send(ASCII9[i], 4'd8, bc);
    check("R9", "mode change ignored", 32'(tx_crc_o), 32'hB4C8);

    // R10: count clamp in token mode, ignored in 16-bit mode
    do_start(1'b0, 1'b0);
    send(8'hB7, 4'd0, bc);
    check("R10", "tok nbits=0 busy", 32'(bc), 32'd8);
    send(8'h4D, 4'd12, bc);
    check("R10", "tok nbits=12 busy", 32'(bc), 32'd8);
    check("R10", "tok clamp rem", 32'(rem_o), 32'(m_crc));
    do_start(1'b1, 1'b0);
    send(8'h6A, 4'd3, bc);
    check("R10", "16-bit nbits ignored busy", 32'(bc), 32'd8);
    check("R10", "16-bit nbits ignored rem", 32'(rem_o), 32'(m_crc));

    // R8: byte offered while busy is rejected, overrun sticky
    do_start(1'b1, 1'b0);
    byte_valid_i = 1'b1; byte_i = 8'h5A; nbits_i = 4'd8;
    @(negedge clk);
    byte_i = 8'hC9;                     // busy now; this one must be rejected
    @(negedge clk);
    byte_valid_i = 1'b0;
    while (busy_o) @(negedge clk);
    m_crc = m_feed(16'hFFFF, 8'h5A, 8, 1'b1, 1'b0);
    check("R8", "overrun set", 32'(overrun_o), 32'd1);
    check("R8", "rejected byte ignored", 32'(rem_o), 32'(m_crc));
    repeat (3) @(negedge clk);
    check("R8", "overrun sticky", 32'(overrun_o), 32'd1);
    do_start(1'b1, 1'b0);
    check("R8", "overrun cleared by start", 32'(overrun_o), 32'd0);

    // R1: start wins over a byte in the same cycle
    start_i = 1'b1; sel16_i = 1'b0; byte_valid_i = 1'b1; byte_i = 8'hFF;
    @(negedge clk);
    start_i = 1'b0; byte_valid_i = 1'b0;
    check("R1", "start priority busy", 32'(busy_o), 32'd0);
    check("R1", "start priority rem", 32'(rem_o), 32'h001F);
    @(negedge clk);
    check("R1", "start priority no overrun", 32'(overrun_o), 32'd0);
    check("R2", "idle hold", 32'(rem_o), 32'h001F);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule